// File: doc/BRIEF.md
# Recursive Sine Oscillator

The block generates a stream of signed sine samples by running a two-pole recursion that sits exactly on the unit circle. It stores the last two outputs. On each enabled sample it multiplies the newer one by a programmed coefficient equal to twice the cosine of the step angle. It then subtracts the older one and saturates the result to the sample width. Each sample costs one multiply and one subtract.

The step angle is 2π times the tone frequency divided by the sample rate. Logic outside the block computes the coefficient and the two seed values from the wanted frequency and amplitude, then supplies them. The seeds are zero for the newer state and minus the amplitude times the sine of the step angle for the older state. A synchronous reset loads them, and the first enabled sample then gives the first point of the tone.

A build parameter chooses between a native multiplier and a shift-and-add partial-product tree for the coefficient product. Both choices give bit-identical results. The shift-and-add form lets a coefficient with few set bits reduce to a handful of adders.

Top module: `osc_core`

## Requirements
- R1: While `rst_i` is high, `valid_o` is 0, `sample_o` is 0, and the state registers load `seed_y1_i` (newer state) and `seed_y2_i` (older state).
- R2: Each enabled sample computes `sat(floor((coef_i*y1 + 8192) / 16384) - y2)`, where y1 and y2 are the newer and older states. The product is therefore rounded half up.
- R3: With seeds 0 and -round(A·sin W), the k-th enabled sample after reset (k = 0, 1, ...) approximates A·sin((k+1)·W). The first valid output equals `coef_i*seed_y1_i` (rounded) minus `seed_y2_i`.
- R4: On every enabled sample, the older state takes the previous newer state, and the newer state takes the new result, both at the same edge.
- R5: `valid_o` is high for exactly one cycle after each clock edge where `sample_en_i` was high and reset was low. When enable is low, `valid_o` is 0 and `sample_o` holds its value.
- R6: A difference above 32767 gives 32767, and one below -32768 gives -32768. It never wraps.
- R7: `coef_i` is signed two's complement with 14 fraction bits. 16'h4000 means +1.0, 16'hC000 means -1.0, and 16'h2000 means +0.5.
- R8: The shift-and-add multiplier build gives the same output as the native multiplier build for every input.
- R9: Over 4096 samples of a tone with amplitude 20000, the output stays within 16 + n/8 counts of the floating-point value at sample n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, loads the seeds |
| sample_en_i | input | 1 | Advance the recursion by one sample |
| coef_i | input | 16 | Twice the cosine of the step angle, signed with 14 fraction bits |
| seed_y1_i | input | 16 | Seed for the newer state, y(-1) |
| seed_y2_i | input | 16 | Seed for the older state, y(-2) |
| sample_o | output | 16 | Signed sine sample |
| valid_o | output | 1 | One-cycle strobe for a new sample |

## Verification
The bench builds two copies that share all inputs. Both use the default 16-bit sample and coefficient widths with 14 fraction bits. One copy uses the native multiplier and the other uses the shift-and-add tree, so every stimulus also compares the two arithmetic variants bit for bit. Because the widths are 16 bits, both saturation limits can be reached with seeds near full scale. Exact rounding ties are reachable with a coefficient of one half. A 4096-sample tone shows how the error grows in a recursion that never decays.

// File: rtl/osc_pkg.sv
package osc_pkg;

    typedef enum logic [0:0] {
        MUL_NATIVE   = 1'b0,
        MUL_SHIFTADD = 1'b1
    } mul_style_e;

    localparam int unsigned DEF_DW    = 16;
    localparam int unsigned DEF_CW    = 16;
    localparam int unsigned DEF_CFRAC = 14;

endpackage

// File: rtl/osc_mul.sv
// Coefficient times state, rounded half up back to sample scale.
module osc_mul #(
    parameter int unsigned          DW    = osc_pkg::DEF_DW,
    parameter int unsigned          CW    = osc_pkg::DEF_CW,
    parameter int unsigned          CFRAC = osc_pkg::DEF_CFRAC,
    parameter osc_pkg::mul_style_e  STYLE = osc_pkg::MUL_NATIVE,
    localparam int unsigned         PW    = DW + CW,
    localparam int unsigned         RW    = PW - CFRAC
) (
    input  logic signed [DW-1:0] a_i,
    input  logic signed [CW-1:0] c_i,
    output logic signed [RW-1:0] p_o
);
    localparam logic signed [PW-1:0] HALF_LSB = PW'(1) <<< (CFRAC - 1);

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] c_ext;
    logic signed [PW-1:0] full_d;
    logic signed [PW-1:0] rnd_d;

    always_comb begin
        a_ext = PW'(a_i);
        c_ext = PW'(c_i);
    end

    generate
        if (STYLE == osc_pkg::MUL_NATIVE) begin : g_native
            always_comb full_d = a_ext * c_ext;
        end else begin : g_shiftadd
            // One partial product per coefficient bit; the sign bit has negative weight.
            always_comb begin
                logic signed [PW-1:0] acc;
                acc = '0;
                for (int i = 0; i < int'(CW); i++) begin
                    if (c_i[i]) begin
                        if (i == int'(CW) - 1) acc = acc - (a_ext <<< i);
                        else                   acc = acc + (a_ext <<< i);
                    end
                end
                full_d = acc;
            end
        end
    endgenerate

    always_comb begin
        rnd_d = full_d + HALF_LSB;
        p_o   = rnd_d[PW-1:CFRAC];
    end

endmodule

// File: rtl/osc_satsub.sv
// Widened difference, clamped to the signed sample range.
module osc_satsub #(
    parameter int unsigned DW = osc_pkg::DEF_DW,
    parameter int unsigned RW = 18,
    localparam int unsigned SW = RW + 1
) (
    input  logic signed [RW-1:0] a_i,
    input  logic signed [DW-1:0] b_i,
    output logic signed [DW-1:0] y_o,
    output logic                 sat_o
);
    localparam logic signed [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};

    logic signed [SW-1:0] diff_d;
    logic                 over_d;

    always_comb begin
        diff_d = SW'(a_i) - SW'(b_i);
        // Fits only if all bits from the sample sign position upward agree.
        over_d = !((&diff_d[SW-1:DW-1]) || !(|diff_d[SW-1:DW-1]));
        sat_o  = over_d;
        if (!over_d)           y_o = diff_d[DW-1:0];
        else if (diff_d[SW-1]) y_o = NEG_LIM;
        else                   y_o = POS_LIM;
    end

endmodule

// File: rtl/osc_core.sv
module osc_core #(
    parameter int unsigned         DW        = osc_pkg::DEF_DW,
    parameter int unsigned         CW        = osc_pkg::DEF_CW,
    parameter int unsigned         CFRAC     = osc_pkg::DEF_CFRAC,
    parameter osc_pkg::mul_style_e MUL_STYLE = osc_pkg::MUL_NATIVE
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 sample_en_i,
    input  logic signed [CW-1:0] coef_i,
    input  logic signed [DW-1:0] seed_y1_i,
    input  logic signed [DW-1:0] seed_y2_i,
    output logic signed [DW-1:0] sample_o,
    output logic                 valid_o
);
    localparam int unsigned RW = DW + CW - CFRAC;

    typedef struct packed {
        logic signed [DW-1:0] y1;
        logic signed [DW-1:0] y2;
        logic signed [DW-1:0] out;
        logic                 vld;
    } osc_state_t;

    osc_state_t state_d, state_q;

    logic signed [RW-1:0] prod_w;
    logic signed [DW-1:0] next_w;
    logic                 sat_w;

    osc_mul #(
        .DW(DW), .CW(CW), .CFRAC(CFRAC), .STYLE(MUL_STYLE)
    ) u_mul (
        .a_i(state_q.y1),
        .c_i(coef_i),
        .p_o(prod_w)
    );

    osc_satsub #(
        .DW(DW), .RW(RW)
    ) u_sub (
        .a_i(prod_w),
        .b_i(state_q.y2),
        .y_o(next_w),
        .sat_o(sat_w)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = 1'b0;
        if (rst_i) begin
            state_d.y1  = seed_y1_i;
            state_d.y2  = seed_y2_i;
            state_d.out = '0;
        end else if (sample_en_i) begin
            state_d.y2  = state_q.y1;
            state_d.y1  = next_w;
            state_d.out = next_w;
            state_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign sample_o = state_q.out;
    assign valid_o  = state_q.vld;

    // Reset loads the seeds and clears the strobe.
    assert_reset_seed_R1: assert property (@(posedge clk_i)
        rst_i |=> (!valid_o && sample_o == '0 &&
                   state_q.y1 == $past(seed_y1_i) && state_q.y2 == $past(seed_y2_i)));

    // The older state takes the previous newer state on each step.
    assert_state_shift_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        sample_en_i |=> (state_q.y2 == $past(state_q.y1)));

    // Idle cycles keep the output and drop the strobe.
    assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !sample_en_i |=> (!valid_o && $stable(sample_o)));

    // A strobe follows only an enabled cycle.
    assert_valid_cause_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> $past(sample_en_i));

    // A saturated step lands on a rail.
    assert_sat_rail_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (sample_en_i && sat_w) |=> (sample_o == {1'b0, {(DW-1){1'b1}}} ||
                                    sample_o == {1'b1, {(DW-1){1'b0}}}));

endmodule

// File: tb/sim_osc_core.sv
module sim_osc_core;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en  = 1'b0;
    logic signed [15:0] coef  = '0;
    logic signed [15:0] seed1 = '0;
    logic signed [15:0] seed2 = '0;
    logic signed [15:0] out0, out1;
    logic              vld0, vld1;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    osc_core u0 (
        .clk_i(clk), .rst_i(rst), .sample_en_i(en), .coef_i(coef),
        .seed_y1_i(seed1), .seed_y2_i(seed2), .sample_o(out0), .valid_o(vld0)
    );

    osc_core #(.MUL_STYLE(osc_pkg::MUL_SHIFTADD)) u1 (
        .clk_i(clk), .rst_i(rst), .sample_en_i(en), .coef_i(coef),
        .seed_y1_i(seed1), .seed_y2_i(seed2), .sample_o(out1), .valid_o(vld1)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model(input int c, input int y1, input int y2);
        longint p, d;
        p = (longint'(c) * longint'(y1) + 64'sd8192) >>> 14;
        d = p - longint'(y2);
        if (d > 32767)  d = 32767;
        if (d < -32768) d = -32768;
        return int'(d);
    endfunction

    task automatic do_reset(input int c, input int s1, input int s2);
        @(negedge clk);
        rst = 1'b1; en = 1'b0;
        coef = 16'(c); seed1 = 16'(s1); seed2 = 16'(s2);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One enabled sample; result read at the following falling edge.
    task automatic step(output int y);
        en = 1'b1;
        @(negedge clk);
        en = 1'b0;
        y = int'(out0);
        chk("R5 valid after enable", longint'(vld0), 1);
        chk("R8 variant match", longint'(out1), longint'(out0));
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b1; seed1 = 16'sd1234; seed2 = -16'sd99;
        @(negedge clk);
        @(negedge clk);
        chk("R1 valid in reset", longint'(vld0), 0);
        chk("R1 sample in reset", longint'(out0), 0);
        rst = 1'b0; en = 1'b0;
    endtask

    task automatic t_first_and_shift();
        int y0, y1v;
        do_reset(30274, 1000, -7654);
        step(y0);
        chk("R3 first output from seeds", y0, model(30274, 1000, -7654));
        step(y1v);
        chk("R4 second output uses shifted state", y1v, model(30274, y0, 1000));
    endtask

    task automatic t_hold();
        int y, held;
        do_reset(30274, 0, -5000);
        step(y);
        held = y;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R5 no strobe when idle", longint'(vld0), 0);
            chk("R5 output held when idle", longint'(out0), held);
        end
    endtask

    task automatic t_format();
        int y;
        do_reset(16'sh4000, 500, 200);
        step(y);
        chk("R7 coef +1.0", y, 300);
        do_reset(-16384, 500, 200);
        step(y);
        chk("R7 coef -1.0", y, -700);
        do_reset(16'sh2000, 3, 0);
        step(y);
        chk("R2 tie rounds up positive", y, 2);
        do_reset(16'sh2000, -3, 0);
        step(y);
        chk("R2 tie rounds up negative", y, -1);
    endtask

    task automatic t_sat();
        int y;
        do_reset(32767, 30000, -30000);
        step(y);
        chk("R6 positive saturation", y, 32767);
        do_reset(32767, -30000, 30000);
        step(y);
        chk("R6 negative saturation", y, -32768);
        do_reset(16'sh4000, 32767, -1);
        step(y);
        chk("R6 one past positive rail", y, 32767);
    endtask

    task automatic t_tone();
        real wq, amp, ref_v, err, bound;
        int  c, s2, ex1, ex2, ex, act;
        c   = $rtoi(2.0 * $cos(2.0 * 3.14159265358979 / 16.0) * 16384.0 + 0.5);
        wq  = $acos(real'(c) / 32768.0);
        s2  = -$rtoi(20000.0 * $sin(wq) + 0.5);
        amp = -real'(s2) / $sin(wq);
        do_reset(c, 0, s2);
        ex1 = 0; ex2 = s2;
        en  = 1'b1;
        for (int n = 0; n < 4096; n++) begin
            @(negedge clk);
            act = int'(out0);
            ex  = model(c, ex1, ex2);
            ex2 = ex1; ex1 = ex;
            chk("R2 tone bit-exact", act, ex);
            chk("R8 tone variant match", longint'(out1), longint'(act));
            ref_v = amp * $sin(real'(n + 1) * wq);
            err   = real'(act) - ref_v;
            if (err < 0.0) err = -err;
            bound = 16.0 + real'(n) / 8.0;
            n_chk++;
            if (err > bound) begin
                n_fail++;
                $display("FAIL R9 R3 sample %0d actual=%0d expected=%0d", n, act, $rtoi(ref_v));
            end
        end
        en = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_first_and_shift();
        t_hold();
        t_format();
        t_sat();
        t_tone();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule